// File: doc/BRIEF.md
# Byte-Order Selectable Word/Byte Lane Converter

This block sits between a host bus that moves 32-bit double words and a byte-wide line path. Going toward the line, it accepts one word together with four active-low byte enables. It then sends the enabled bytes out one per handshake. Coming from the line, it gathers bytes into a word, puts each byte on a lane, and hands the word to the host with a valid flag and a per-lane valid mask.

A single mode input chooses between big-endian and little-endian byte order, and both directions follow it. In big-endian order the upper lane goes first; in little-endian order the lower lane goes first. Lane k always means bits [8k+7:8k], and a byte enable always names the same physical lane in either mode. The converter samples the mode once per word, so a change made part-way through a word applies from the next word. All four interfaces use ready/valid handshakes.

Top module: `endian_lane_conv`

## Requirements
- R1: After reset, tx_ready_o=1, ln_tx_valid_o=0, rx_valid_o=0 and ln_rx_ready_o=1.
- R2: With big_endian_i=1, a transmitted word's enabled bytes leave in lane order 3, 2, 1, 0.
- R3: With big_endian_i=0, a transmitted word's enabled bytes leave in lane order 0, 1, 2, 3.
- R4: tx_be_ni[k]=0 enables lane k (bits [8k+7:8k]) in both modes. Lanes whose enable is 1 are skipped, and an accepted word with any enabled lane raises ln_tx_valid_o on the next cycle.
- R5: A word accepted with tx_be_ni=4'hF emits no byte, and tx_ready_o is high again on the next cycle.
- R6: With big_endian_i=1, the i-th received byte of a word (i=0..3) is placed on lane 3-i.
- R7: With big_endian_i=0, the i-th received byte of a word is placed on lane i.
- R8: A byte accepted with ln_rx_last_i=1 completes the word, and rx_valid_o rises on the next cycle. rx_lane_vld_o[k]=1 marks each filled lane, and unfilled lanes read as zero. A fourth byte completes the word without ln_rx_last_i.
- R9: The mode is sampled once per word: on transmit when the word is accepted, and on receive when its first byte is accepted. A change after that takes effect from the next word.
- R10: While ln_tx_valid_o=1 and ln_tx_ready_i=0, ln_tx_byte_o holds. While rx_valid_o=1 and rx_ready_i=0, rx_word_o and rx_lane_vld_o hold. No new line byte is accepted while a received word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | 1 = big-endian byte order, 0 = little-endian |
| tx_word_i | input | 32 | Host word to transmit |
| tx_be_ni | input | 4 | Active-low byte enables, bit k = lane k |
| tx_valid_i | input | 1 | Host word valid |
| tx_ready_o | output | 1 | Converter can take a host word |
| ln_tx_byte_o | output | 8 | Outgoing line byte |
| ln_tx_valid_o | output | 1 | Outgoing byte valid |
| ln_tx_ready_i | input | 1 | Line side takes the byte |
| ln_rx_byte_i | input | 8 | Incoming line byte |
| ln_rx_valid_i | input | 1 | Incoming byte valid |
| ln_rx_last_i | input | 1 | Incoming byte ends the frame |
| ln_rx_ready_o | output | 1 | Converter can take a line byte |
| rx_word_o | output | 32 | Assembled host word |
| rx_lane_vld_o | output | 4 | Lanes of rx_word_o that hold data |
| rx_valid_o | output | 1 | Assembled word valid |
| rx_ready_i | input | 1 | Host takes the word |

## Verification
The bench sends sparse enable patterns such as a single middle lane or alternate lanes in both modes. A design that tied enables to transmit position rather than physical lane would send the wrong bytes. It sends an all-disabled word, which would hang or emit a stray byte in a design that waits for at least one byte. It flips the mode part-way through a word in both directions, which catches a design that reorders live or splits a word between two orders. It also checks partial frames ended by the last flag, where a wrong design would leave lanes stale or misplace the bytes for little-endian order, and it stalls both outputs to catch data that changes under backpressure.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic {ORD_LE = 1'b0, ORD_BE = 1'b1} order_e;
endpackage

// File: rtl/lane_tx_ser.sv
module lane_tx_ser import lane_pkg::*; #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = LANES * BYTE_W,
  localparam int unsigned IDX_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANES-1:0]  be_ni,
  input  logic              valid_i,
  output logic              ready_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              bvalid_o,
  input  logic              bready_i
);
  logic [WORD_W-1:0] word_q;
  logic [LANES-1:0]  pend_q;
  order_e            ord_q;
  logic [IDX_W-1:0]  sel;

  assign ready_o  = ~|pend_q;
  assign bvalid_o = |pend_q;

  // LE: lowest pending lane; BE: highest pending lane
  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < LANES; k++) begin
      if (pend_q[k]) begin
        if (ord_q == ORD_BE) begin
          sel = IDX_W'(k);
        end else if (!found) begin
          sel   = IDX_W'(k);
          found = 1'b1;
        end
      end
    end
  end

  assign byte_o = word_q[sel*BYTE_W +: BYTE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      pend_q <= '0;
      ord_q  <= ORD_LE;
    end else if (valid_i && ready_o) begin
      word_q <= word_i;
      pend_q <= ~be_ni;
      ord_q  <= mode_i ? ORD_BE : ORD_LE;
    end else if (bvalid_o && bready_i) begin
      pend_q <= pend_q & ~(LANES'(1) << sel);
    end
  end
endmodule

// File: rtl/lane_rx_pack.sv
module lane_rx_pack import lane_pkg::*; #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = LANES * BYTE_W,
  localparam int unsigned IDX_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              bvalid_i,
  input  logic              blast_i,
  output logic              bready_o,
  output logic [WORD_W-1:0] word_o,
  output logic [LANES-1:0]  lane_vld_o,
  output logic              valid_o,
  input  logic              ready_i
);
  logic [IDX_W-1:0]  cnt_q;
  order_e            ord_q;
  order_e            cur_ord;
  logic [IDX_W-1:0]  lane;
  logic              out_vld_q;
  logic              take;
  logic              first;
  logic              close;
  logic [WORD_W-1:0] acc_q;
  logic [LANES-1:0]  lvld_q;

  assign bready_o = ~out_vld_q;
  assign take     = bvalid_i & bready_o;
  assign first    = (cnt_q == '0);
  assign close    = blast_i | (cnt_q == IDX_W'(LANES-1));
  // mode is captured on the first byte of each word
  assign cur_ord  = first ? (mode_i ? ORD_BE : ORD_LE) : ord_q;
  assign lane     = (cur_ord == ORD_BE) ? IDX_W'(LANES-1) - cnt_q : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      ord_q     <= ORD_LE;
      out_vld_q <= 1'b0;
    end else if (take) begin
      cnt_q <= close ? '0 : cnt_q + 1'b1;
      if (first) ord_q <= cur_ord;
      if (close) out_vld_q <= 1'b1;
    end else if (out_vld_q && ready_i) begin
      out_vld_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[g*BYTE_W +: BYTE_W] <= '0;
        lvld_q[g]                 <= 1'b0;
      end else if (take) begin
        if (lane == IDX_W'(g)) begin
          acc_q[g*BYTE_W +: BYTE_W] <= byte_i;
          lvld_q[g]                 <= 1'b1;
        end else if (first) begin
          acc_q[g*BYTE_W +: BYTE_W] <= '0;
          lvld_q[g]                 <= 1'b0;
        end
      end
    end
  end

  assign word_o     = acc_q;
  assign lane_vld_o = lvld_q;
  assign valid_o    = out_vld_q;
endmodule

// File: rtl/endian_lane_conv.sv
module endian_lane_conv #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_endian_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic [LANES-1:0]  tx_be_ni,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [BYTE_W-1:0] ln_tx_byte_o,
  output logic              ln_tx_valid_o,
  input  logic              ln_tx_ready_i,
  input  logic [BYTE_W-1:0] ln_rx_byte_i,
  input  logic              ln_rx_valid_i,
  input  logic              ln_rx_last_i,
  output logic              ln_rx_ready_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic [LANES-1:0]  rx_lane_vld_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i
);
  lane_tx_ser #(.LANES(LANES), .BYTE_W(BYTE_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (big_endian_i),
    .word_i   (tx_word_i),
    .be_ni    (tx_be_ni),
    .valid_i  (tx_valid_i),
    .ready_o  (tx_ready_o),
    .byte_o   (ln_tx_byte_o),
    .bvalid_o (ln_tx_valid_o),
    .bready_i (ln_tx_ready_i)
  );

  lane_rx_pack #(.LANES(LANES), .BYTE_W(BYTE_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (big_endian_i),
    .byte_i     (ln_rx_byte_i),
    .bvalid_i   (ln_rx_valid_i),
    .blast_i    (ln_rx_last_i),
    .bready_o   (ln_rx_ready_o),
    .word_o     (rx_word_o),
    .lane_vld_o (rx_lane_vld_o),
    .valid_o    (rx_valid_o),
    .ready_i    (rx_ready_i)
  );
endmodule

// File: rtl/lane_conv_chk.sv
module lane_conv_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LANES-1:0]  tx_be_ni,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic [BYTE_W-1:0] ln_tx_byte_o,
  input logic              ln_tx_valid_o,
  input logic              ln_tx_ready_i,
  input logic              ln_rx_valid_i,
  input logic              ln_rx_last_i,
  input logic              ln_rx_ready_o,
  input logic [WORD_W-1:0] rx_word_o,
  input logic [LANES-1:0]  rx_lane_vld_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i
);
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ln_tx_valid_o && !ln_tx_ready_i |=> ln_tx_valid_o && $stable(ln_tx_byte_o)); // R10
  AST_TX_EMPTY_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_o && (&tx_be_ni) |=> !ln_tx_valid_o && tx_ready_o); // R5
  AST_TX_WORD_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_o && !(&tx_be_ni) |=> ln_tx_valid_o && !tx_ready_o); // R4
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_word_o) && $stable(rx_lane_vld_o)); // R10
  AST_RX_LAST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ln_rx_valid_i && ln_rx_ready_o && ln_rx_last_i |=> rx_valid_o); // R8
  AST_RX_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> rx_lane_vld_o != '0); // R8
endmodule

bind endian_lane_conv lane_conv_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_be_ni      (tx_be_ni),
  .tx_valid_i    (tx_valid_i),
  .tx_ready_o    (tx_ready_o),
  .ln_tx_byte_o  (ln_tx_byte_o),
  .ln_tx_valid_o (ln_tx_valid_o),
  .ln_tx_ready_i (ln_tx_ready_i),
  .ln_rx_valid_i (ln_rx_valid_i),
  .ln_rx_last_i  (ln_rx_last_i),
  .ln_rx_ready_o (ln_rx_ready_o),
  .rx_word_o     (rx_word_o),
  .rx_lane_vld_o (rx_lane_vld_o),
  .rx_valid_o    (rx_valid_o),
  .rx_ready_i    (rx_ready_i)
);

// File: tb/sim_endian_lane_conv.sv
`timescale 1ns/1ps
module sim_endian_lane_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian_i = 1'b0;
  logic [31:0] tx_word_i = '0;
  logic [3:0]  tx_be_ni = 4'hF;
  logic        tx_valid_i = 1'b0;
  logic        tx_ready_o;
  logic [7:0]  ln_tx_byte_o;
  logic        ln_tx_valid_o;
  logic        ln_tx_ready_i = 1'b1;
  logic [7:0]  ln_rx_byte_i = '0;
  logic        ln_rx_valid_i = 1'b0;
  logic        ln_rx_last_i = 1'b0;
  logic        ln_rx_ready_o;
  logic [31:0] rx_word_o;
  logic [3:0]  rx_lane_vld_o;
  logic        rx_valid_o;
  logic        rx_ready_i = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  endian_lane_conv u0 (
    .clk_i(clk), .rst_ni(rst_n), .big_endian_i(big_endian_i),
    .tx_word_i(tx_word_i), .tx_be_ni(tx_be_ni), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .ln_tx_byte_o(ln_tx_byte_o), .ln_tx_valid_o(ln_tx_valid_o), .ln_tx_ready_i(ln_tx_ready_i),
    .ln_rx_byte_i(ln_rx_byte_i), .ln_rx_valid_i(ln_rx_valid_i), .ln_rx_last_i(ln_rx_last_i),
    .ln_rx_ready_o(ln_rx_ready_o), .rx_word_o(rx_word_o), .rx_lane_vld_o(rx_lane_vld_o),
    .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // host word out to the line; flip toggles mode after acceptance, stall throttles line ready
  task automatic tx_case(input string req, input logic [31:0] w, input logic [3:0] ben,
                         input logic big, input logic flip, input logic stall);
    logic [7:0] exp_b[4];
    int ne = 0;
    int ng = 0;
    for (int k = 0; k < 4; k++) begin
      int ln;
      ln = big ? 3 - k : k;
      if (!ben[ln]) begin exp_b[ne] = w[ln*8 +: 8]; ne++; end
    end
    @(negedge clk);
    big_endian_i = big; tx_word_i = w; tx_be_ni = ben; tx_valid_i = 1'b1;
    #1 chk({req, " ready"}, {31'd0, tx_ready_o}, 32'd1);
    @(negedge clk);
    tx_valid_i = 1'b0;
    if (flip) big_endian_i = ~big;
    for (int cyc = 0; cyc < 12; cyc++) begin
      ln_tx_ready_i = stall ? cyc[0] : 1'b1;
      #1;
      if (ln_tx_valid_o && ln_tx_ready_i) begin
        if (ng < ne) chk({req, " byte"}, {24'd0, ln_tx_byte_o}, {24'd0, exp_b[ng]});
        ng++;
      end
      @(negedge clk);
    end
    ln_tx_ready_i = 1'b1;
    #1;
    chk({req, " count"}, ng, ne);
    chk({req, " idle"}, {31'd0, tx_ready_o}, 32'd1);
    big_endian_i = big;
  endtask

  // n line bytes (byte i at bits[8i+:8]) into one host word
  task automatic rx_case(input string req, input logic [31:0] bs, input int n, input logic last,
                         input logic big, input logic flip, input logic stall);
    logic [31:0] exp_w = '0;
    logic [3:0]  exp_l = '0;
    logic [31:0] held;
    for (int i = 0; i < n; i++) begin
      int ln;
      ln = big ? 3 - i : i;
      exp_w[ln*8 +: 8] = bs[i*8 +: 8];
      exp_l[ln] = 1'b1;
    end
    big_endian_i = big;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (flip && i == 1) big_endian_i = ~big;
      ln_rx_byte_i = bs[i*8 +: 8]; ln_rx_valid_i = 1'b1; ln_rx_last_i = last && (i == n - 1);
      #1 chk({req, " rx ready"}, {31'd0, ln_rx_ready_o}, 32'd1);
    end
    @(negedge clk);
    ln_rx_valid_i = 1'b0; ln_rx_last_i = 1'b0;
    #1;
    chk({req, " valid"}, {31'd0, rx_valid_o}, 32'd1);
    chk({req, " word"}, rx_word_o, exp_w);
    chk({req, " lanes"}, {28'd0, rx_lane_vld_o}, {28'd0, exp_l});
    if (stall) begin
      held = rx_word_o;
      repeat (2) @(negedge clk);
      #1;
      chk("R10 rx hold word", rx_word_o, held);
      chk("R10 rx no accept", {31'd0, ln_rx_ready_o}, 32'd0);
    end
    rx_ready_i = 1'b1;
    @(negedge clk);
    rx_ready_i = 1'b0;
    #1 chk({req, " drained"}, {31'd0, rx_valid_o}, 32'd0);
    big_endian_i = big;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 tx_ready", {31'd0, tx_ready_o}, 32'd1);
    chk("R1 ln_tx_valid", {31'd0, ln_tx_valid_o}, 32'd0);
    chk("R1 rx_valid", {31'd0, rx_valid_o}, 32'd0);
    chk("R1 ln_rx_ready", {31'd0, ln_rx_ready_o}, 32'd1);

    tx_case("R2 be full",      32'hA1B2C3D4, 4'h0, 1'b1, 1'b0, 1'b0);
    tx_case("R3 le full",      32'hA1B2C3D4, 4'h0, 1'b0, 1'b0, 1'b0);
    tx_case("R4 be sparse",    32'h11223344, 4'b0101, 1'b1, 1'b0, 1'b0);
    tx_case("R4 le sparse",    32'h11223344, 4'b1010, 1'b0, 1'b0, 1'b0);
    tx_case("R4 le one lane",  32'h55667788, 4'b1011, 1'b0, 1'b0, 1'b0);
    tx_case("R5 none enabled", 32'hDEADBEEF, 4'hF, 1'b1, 1'b0, 1'b0);
    tx_case("R9 tx flip be",   32'h0BADF00D, 4'h0, 1'b1, 1'b1, 1'b0);
    tx_case("R9 tx flip le",   32'h0BADF00D, 4'h0, 1'b0, 1'b1, 1'b0);
    tx_case("R10 tx stall",    32'hCAFE1234, 4'h0, 1'b1, 1'b0, 1'b1);

    rx_case("R6 be full",      32'h44332211, 4, 1'b0, 1'b1, 1'b0, 1'b0);
    rx_case("R7 le full",      32'h44332211, 4, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_case("R8 be partial",   32'h00CCBBAA, 3, 1'b1, 1'b1, 1'b0, 1'b0);
    rx_case("R8 le partial",   32'h0000BBAA, 2, 1'b1, 1'b0, 1'b0, 1'b0);
    rx_case("R8 le single",    32'h000000EE, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    rx_case("R9 rx flip be",   32'h87654321, 4, 1'b0, 1'b1, 1'b1, 1'b0);
    rx_case("R9 rx flip le",   32'h00654321, 3, 1'b1, 1'b0, 1'b1, 1'b0);
    rx_case("R10 rx stall",    32'h9ABCDEF0, 4, 1'b1, 1'b1, 1'b0, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule